// File: doc/BRIEF.md
# Command transaction sequencer

This engine runs one complete command exchange with a housekeeping microcontroller that sits behind a small mailbox register block. The mailbox has three word registers: an interrupt register, a data register and a status register. A caller supplies an opcode, an argument count and up to four argument bytes, and a count of expected result bytes. The engine first clears stale status. It then sends the opcode and the arguments, reads back one acknowledge byte, and collects the result bytes. When it finishes it presents the acknowledge byte, the result bytes and a 16-bit big-endian word built from the first two results.

Every wait on the mailbox is bounded by a poll counter. Transmit polls run back to back. Receive polls are spaced by a clock divider that stands for a one-microsecond interval. If a wait runs out, the engine does not abort. It raises a sticky timeout flag and carries on with the access it was waiting to make. The engine owns the mailbox as a simple bus master. Each access takes one cycle, and read data is valid in the same cycle as the request.

Top module: `cts_seq`

## Requirements
- R1: A `start_i` pulse while idle latches the opcode, the counts and the arguments, and raises `busy_o` in the next cycle. At the end, `done_o` is high for exactly one cycle and `busy_o` is low in the cycle after it.
- R2: Every transaction begins with three accesses in this order: a read of the status register (address 2), a read of the interrupt register (address 0), then a write to the status register of the exact value that the first read returned.
- R3: Data register writes (address 1) carry the opcode first, then `arg_cnt_i` argument bytes, starting with argument 0 from `args_i[7:0]` and moving upward byte by byte. No other data writes occur. Both counts must not exceed MAX_BYTES.
- R4: Before each data write, status bit 1 (transmit not full) is polled. The write happens as soon as the bit reads 1, or after POLL_LIMIT polls at most. If the limit is reached, `timeout_o` is set.
- R5: Before each data read, status bit 2 (receive not empty) is polled. Consecutive polls are exactly TICK_CYCLES cycles apart. If the bit is still clear after POLL_LIMIT polls, `timeout_o` is set and the data register is read anyway.
- R6: Each data read is followed at once by a status write of the value 0x4, which acknowledges the received byte.
- R7: A transmitted byte sits in bits 15:8 of the data word, with all other bits zero. A received byte is taken from bits 15:8.
- R8: The first byte received appears on `ack_o`. Result byte k appears on `res_o[8k+7:8k]`. Result slots that were not received read as zero.
- R9: `word_o` has result byte 0 as its high byte and result byte 1 as its low byte.
- R10: `timeout_o` is sticky for the rest of the transaction and is cleared when the next start is accepted.
- R11: A start pulse that arrives while `busy_o` is high is ignored. It causes no bus access, no extra `done_o` and no change to the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| opcode_i | input | 8 | Command opcode |
| arg_cnt_i | input | 3 | Number of argument bytes (0 to MAX_BYTES) |
| args_i | input | 32 | Argument bytes, argument 0 in bits 7:0 |
| res_cnt_i | input | 3 | Number of result bytes expected (0 to MAX_BYTES) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 8 | Acknowledge byte |
| res_o | output | 32 | Result bytes, result 0 in bits 7:0 |
| word_o | output | 16 | Big-endian word built from results 0 and 1 |
| timeout_o | output | 1 | Sticky poll timeout flag |
| bus_req_o | output | 1 | Mailbox access request |
| bus_we_o | output | 1 | Mailbox write enable |
| bus_addr_o | output | 2 | Mailbox word address: 0 interrupt, 1 data, 2 status |
| bus_wdata_o | output | 32 | Mailbox write data |
| bus_rdata_i | input | 32 | Mailbox read data, valid in the request cycle |

## Verification
The assertions assume that the caller never asks for more than MAX_BYTES arguments or results. They also assume that the mailbox returns read data in the same cycle as the request. The bench mailbox model answers every request at once, and every transaction the bench issues stays within the count limits. The model reports transmit full for a chosen number of status reads, which drives the transmit polls both below and past the poll limit. It releases the queued acknowledge and result bytes only after it sees the opcode write, so that the stale-status clear never consumes the response. Receive-side timeouts come from leaving that response empty.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_INTR,
    S_WR_STAT,
    S_TX_POLL,
    S_TX_WR,
    S_RX_POLL,
    S_RX_WAIT,
    S_RX_RD,
    S_RX_ACK,
    S_DONE
  } cts_state_e;

  localparam logic [1:0] REG_INTR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam int STAT_TXNF_BIT = 1;
  localparam int STAT_RXNE_BIT = 2;
  localparam int LANE_LSB      = 8;

endpackage

// File: rtl/cts_pace.sv
// Spacing divider: expire_o after TICK_CYCLES-1 cycles of run_i.
module cts_pace #(
  parameter int TICK_CYCLES = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 2);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  a_r5_pace_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/cts_poll_ctr.sv
// Counts polls of one wait; last_o marks the final allowed poll.
module cts_poll_ctr #(
  parameter int POLL_LIMIT = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !last_o)  cnt_q <= cnt_q + 1'b1;
  end

  a_r4_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_LIMIT));

  a_r5_clr_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !last_o || (POLL_LIMIT == 1));

endmodule

// File: rtl/cts_rx_store.sv
// Holds the acknowledge byte and result bytes of the current transaction.
module cts_rx_store #(
  parameter int MAX_BYTES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [7:0]             byte_i,
  output logic [7:0]             ack_o,
  output logic [8*MAX_BYTES-1:0] res_o,
  output logic [15:0]            word_o
);
  localparam int IW = $clog2(MAX_BYTES + 1);

  logic [7:0] ack_q;
  logic [7:0] res_q [MAX_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ack_q <= '0;
    else if (clr_i)                      ack_q <= '0;
    else if (wr_i && idx_i == '0)        ack_q <= byte_i;
  end

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             res_q[k] <= '0;
      else if (clr_i)                          res_q[k] <= '0;
      else if (wr_i && idx_i == IW'(k + 1))    res_q[k] <= byte_i;
    end
    assign res_o[8*k +: 8] = res_q[k];
  end

  assign ack_o  = ack_q;
  assign word_o = {res_q[0], res_q[1]};

  a_r8_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> idx_i <= IW'(MAX_BYTES));

  a_r8_ack_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == '0 && !clr_i) |=> ack_o == $past(byte_i));

endmodule

// File: rtl/cts_seq.sv
module cts_seq
  import cts_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int POLL_LIMIT  = 10000,
  parameter int TICK_CYCLES = 125,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [7:0]             opcode_i,
  input  logic [CNT_W-1:0]       arg_cnt_i,
  input  logic [8*MAX_BYTES-1:0] args_i,
  input  logic [CNT_W-1:0]       res_cnt_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [7:0]             ack_o,
  output logic [8*MAX_BYTES-1:0] res_o,
  output logic [15:0]            word_o,
  output logic                   timeout_o,
  output logic                   bus_req_o,
  output logic                   bus_we_o,
  output logic [1:0]             bus_addr_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  input  logic [DATA_W-1:0]      bus_rdata_i
);
  localparam logic [DATA_W-1:0] RXNE_MASK = DATA_W'(1) << STAT_RXNE_BIT;

  cts_state_e             state_q;
  logic [7:0]             op_q;
  logic [8*MAX_BYTES-1:0] args_q;
  logic [CNT_W-1:0]       nargs_q, nres_q;
  logic [CNT_W-1:0]       tx_idx_q, rx_idx_q;
  logic [DATA_W-1:0]      stat_q;
  logic                   timeout_q;

  logic                   poll_clr, poll_inc, poll_last;
  logic                   pace_expire;
  logic [7:0]             tx_bytes [MAX_BYTES+1];
  logic [7:0]             tx_byte;
  logic                   accept;

  assign accept = (state_q == S_IDLE) && start_i;

  // transmit byte selection: slot 0 opcode, slot k+1 argument k
  assign tx_bytes[0] = op_q;
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_txb
    assign tx_bytes[k+1] = args_q[8*k +: 8];
  end
  assign tx_byte = tx_bytes[tx_idx_q];

  assign poll_clr = (state_q == S_IDLE) || (state_q == S_WR_STAT) ||
                    (state_q == S_TX_WR) || (state_q == S_RX_ACK);
  assign poll_inc = (state_q == S_TX_POLL) || (state_q == S_RX_POLL);

  cts_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) i_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  cts_pace #(.TICK_CYCLES(TICK_CYCLES)) i_pace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == S_RX_WAIT),
    .expire_o (pace_expire)
  );

  cts_rx_store #(.MAX_BYTES(MAX_BYTES)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .wr_i   (state_q == S_RX_RD),
    .idx_i  (rx_idx_q),
    .byte_i (bus_rdata_i[LANE_LSB +: 8]),
    .ack_o  (ack_o),
    .res_o  (res_o),
    .word_o (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      args_q    <= '0;
      nargs_q   <= '0;
      nres_q    <= '0;
      tx_idx_q  <= '0;
      rx_idx_q  <= '0;
      stat_q    <= '0;
      timeout_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q      <= opcode_i;
          args_q    <= args_i;
          nargs_q   <= arg_cnt_i;
          nres_q    <= res_cnt_i;
          timeout_q <= 1'b0;
          state_q   <= S_RD_STAT;
        end
        S_RD_STAT: begin
          stat_q  <= bus_rdata_i;
          state_q <= S_RD_INTR;
        end
        S_RD_INTR: state_q <= S_WR_STAT;
        S_WR_STAT: begin
          tx_idx_q <= '0;
          state_q  <= S_TX_POLL;
        end
        S_TX_POLL: begin
          if (bus_rdata_i[STAT_TXNF_BIT]) begin
            state_q <= S_TX_WR;
          end else if (poll_last) begin
            timeout_q <= 1'b1;
            state_q   <= S_TX_WR;
          end
        end
        S_TX_WR: begin
          if (tx_idx_q == nargs_q) begin
            rx_idx_q <= '0;
            state_q  <= S_RX_POLL;
          end else begin
            tx_idx_q <= tx_idx_q + 1'b1;
            state_q  <= S_TX_POLL;
          end
        end
        S_RX_POLL: begin
          if (bus_rdata_i[STAT_RXNE_BIT]) begin
            state_q <= S_RX_RD;
          end else if (poll_last) begin
            timeout_q <= 1'b1;
            state_q   <= S_RX_RD;
          end else begin
            state_q <= S_RX_WAIT;
          end
        end
        S_RX_WAIT: if (pace_expire) state_q <= S_RX_POLL;
        S_RX_RD:   state_q <= S_RX_ACK;
        S_RX_ACK: begin
          if (rx_idx_q == nres_q) begin
            state_q <= S_DONE;
          end else begin
            rx_idx_q <= rx_idx_q + 1'b1;
            state_q  <= S_RX_POLL;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = REG_STAT;
    bus_wdata_o = '0;
    unique case (state_q)
      S_RD_STAT: bus_req_o = 1'b1;
      S_RD_INTR: begin
        bus_req_o  = 1'b1;
        bus_addr_o = REG_INTR;
      end
      S_WR_STAT: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = stat_q;
      end
      S_TX_POLL: bus_req_o = 1'b1;
      S_TX_WR: begin
        bus_req_o                   = 1'b1;
        bus_we_o                    = 1'b1;
        bus_addr_o                  = REG_DATA;
        bus_wdata_o[LANE_LSB +: 8]  = tx_byte;
      end
      S_RX_POLL: bus_req_o = 1'b1;
      S_RX_RD: begin
        bus_req_o  = 1'b1;
        bus_addr_o = REG_DATA;
      end
      S_RX_ACK: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = RXNE_MASK;
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign timeout_o = timeout_q;

  // caller contract
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> (arg_cnt_i <= CNT_W'(MAX_BYTES) && res_cnt_i <= CNT_W'(MAX_BYTES)));

  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r2_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_STAT) |-> (bus_we_o && bus_wdata_o == $past(bus_rdata_i, 2)));

  a_r7_tx_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == REG_DATA) |->
      (bus_wdata_o[LANE_LSB-1:0] == '0 && bus_wdata_o[DATA_W-1:LANE_LSB+8] == '0));

  a_r6_ack_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_addr_o == REG_DATA) |=>
      (bus_req_o && bus_we_o && bus_addr_o == REG_STAT && bus_wdata_o == RXNE_MASK));

  a_r10_timeout_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> !timeout_o);

  a_r10_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(start_i && !busy_o)) |=> timeout_o);

  a_r11_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: tb/test_cts_seq.sv
`timescale 1ns/1ps
module test_cts_seq;
  localparam int MAXB = 4;
  localparam int LIM  = 16;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [2:0]  arg_cnt = '0;
  logic [31:0] args = '0;
  logic [2:0]  res_cnt = '0;
  logic        busy, done, tmo;
  logic [7:0]  ack;
  logic [31:0] res;
  logic [15:0] word;
  logic        bus_req, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  cts_seq #(.MAX_BYTES(MAXB), .POLL_LIMIT(LIM), .TICK_CYCLES(TICK)) i_cts_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .arg_cnt_i(arg_cnt), .args_i(args), .res_cnt_i(res_cnt),
    .busy_o(busy), .done_o(done), .ack_o(ack), .res_o(res), .word_o(word),
    .timeout_o(tmo), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  typedef struct {
    logic [7:0]  ack;
    logic [31:0] res;
    logic [15:0] word;
    logic        tmo;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] exp_tx[$];
  logic [7:0] pend_q[$];
  logic [7:0] rx_mem[$];

  int n_chk = 0, n_fail = 0;
  int tx_stall = 0, tx_seen = 0;
  int acc_idx = 0, cyc = 0, last_cyc = 0, rx_polls = 0, last_rx_polls = 0;
  int done_cnt = 0;
  bit gap_valid = 0, prev_done = 0, ended = 0;
  logic [31:0] stat_seen = '0;

  logic       rx_has = 1'b0, tx_full = 1'b0;
  logic [7:0] rx_head = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // mailbox model: read data valid in the request cycle
  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = 32'h0000_0044;
      2'd1:    bus_rdata = {16'h0, rx_head, 8'h0};
      2'd2:    bus_rdata = {29'h0, rx_has, ~tx_full, 1'b1};
      default: bus_rdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (bus_req && bus_we && bus_addr == 2'd1) begin
      if (tx_seen == 0) begin
        foreach (pend_q[i]) rx_mem.push_back(pend_q[i]);
        pend_q.delete();
      end
      tx_seen++;
    end
    if (bus_req && bus_we && bus_addr == 2'd2 && bus_wdata[2] && rx_mem.size() > 0)
      void'(rx_mem.pop_front());
    if (bus_req && !bus_we && bus_addr == 2'd2 && tx_stall > 0)
      tx_stall--;
    rx_has  <= (rx_mem.size() > 0);
    rx_head <= (rx_mem.size() > 0) ? rx_mem[0] : 8'h00;
    tx_full <= (tx_stall > 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (done && prev_done) chk("R1 done width", 1, 0);
      prev_done = done;
      if (bus_req) begin
        automatic bit in_rx = (exp_tx.size() == 0) && (acc_idx >= 3);
        if (acc_idx == 0) begin
          chk("R2 first access rd stat", {bus_we, bus_addr}, {1'b0, 2'd2});
          stat_seen = bus_rdata;
        end else if (acc_idx == 1) begin
          chk("R2 second access rd intr", {bus_we, bus_addr}, {1'b0, 2'd0});
        end else if (acc_idx == 2) begin
          chk("R2 third access wr stat", {bus_we, bus_addr}, {1'b1, 2'd2});
          chk("R2 writeback value", bus_wdata, stat_seen);
        end
        if (bus_we && bus_addr == 2'd1) begin
          chk("R7 tx lane", {bus_wdata[31:16], bus_wdata[7:0]}, 0);
          if (exp_tx.size() == 0) chk("R11 unexpected data write", bus_wdata, 0);
          else chk("R3 tx byte order", bus_wdata[15:8], exp_tx.pop_front());
        end
        if (in_rx && bus_we && bus_addr == 2'd2)
          chk("R6 rx acknowledge value", bus_wdata, 32'h4);
        if (in_rx && !bus_we && bus_addr == 2'd2) begin
          if (gap_valid) chk("R5 poll spacing", cyc - last_cyc, TICK);
          last_cyc  = cyc;
          gap_valid = 1;
          rx_polls++;
        end
        if (in_rx && !bus_we && bus_addr == 2'd1) begin
          last_rx_polls = rx_polls;
          rx_polls  = 0;
          gap_valid = 0;
        end
        acc_idx++;
      end
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) chk("R11 unexpected done", 1, 0);
        else begin
          automatic exp_t e = exp_q.pop_front();
          chk("R8 ack byte", ack, e.ack);
          chk("R8 result bytes", res, e.res);
          chk("R9 result word", word, e.word);
          chk("R10 timeout flag", tmo, e.tmo);
        end
      end
    end
  end

  task automatic run_txn(input logic [7:0] op, input int nargs, input logic [31:0] a,
                         input int nres, input int nresp, input logic [39:0] resp,
                         input int stall, input logic exp_tmo, input bit poke);
    exp_t e;
    int n;
    @(negedge clk);
    exp_tx.push_back(op);
    for (int k = 0; k < nargs; k++) exp_tx.push_back(a[8*k +: 8]);
    for (int k = 0; k < nresp; k++) pend_q.push_back(resp[8*k +: 8]);
    e.ack = (nresp > 0) ? resp[7:0] : 8'h00;
    e.res = '0;
    for (int k = 0; k < nres; k++)
      if (k + 1 < nresp) e.res[8*k +: 8] = resp[8*(k+1) +: 8];
    e.word = {e.res[7:0], e.res[15:8]};
    e.tmo  = exp_tmo;
    exp_q.push_back(e);
    tx_stall = stall; tx_seen = 0; acc_idx = 0; gap_valid = 0; rx_polls = 0;
    opcode = op; arg_cnt = 3'(nargs); args = a; res_cnt = 3'(nres); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", busy, 1);
    chk("R10 timeout cleared on start", tmo, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      opcode = 8'hEE; arg_cnt = 3'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = done_cnt;
    while (done_cnt == n) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R1 idle after done", {busy, done}, 2'b00);
    chk("R3 all tx bytes sent", exp_tx.size(), 0);
    chk("R11 single done", done_cnt, n + 1);
    tx_stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done/timeout/req", {busy, done, tmo, bus_req}, 4'b0);
    chk("R8 reset ack/word", {ack, word}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // event-status style: no args, two results
    run_txn(8'h0C, 0, 32'h0, 2, 3, 40'h34_12_A5, 0, 1'b0, 0);
    // external-status style
    run_txn(8'h11, 0, 32'h0, 2, 3, 40'h01_80_00, 0, 1'b0, 0);
    // full arguments and results
    run_txn(8'h41, 4, 32'hD4C3B2A1, 4, 5, 40'h44_33_22_11_5A, 0, 1'b0, 0);
    // no arguments, no results: acknowledge only
    run_txn(8'h30, 0, 32'h0, 0, 1, 40'h00_00_00_00_C3, 0, 1'b0, 0);
    // fewer results than slots: remaining slots zero
    run_txn(8'h24, 1, 32'h0000_007F, 1, 2, 40'h9E_3C, 0, 1'b0, 0);
    // R4: transmit full for a few polls, no timeout
    run_txn(8'h23, 2, 32'h0000_0605, 2, 3, 40'hBB_AA_01, 4, 1'b0, 0);
    // R4: transmit full beyond the limit, byte still written
    run_txn(8'h34, 0, 32'h0, 0, 1, 40'h6B, LIM + 24, 1'b1, 0);
    // R5: no response at all, every receive wait times out
    run_txn(8'h07, 0, 32'h0, 2, 0, 40'h0, 0, 1'b1, 0);
    chk("R5 poll count at limit", last_rx_polls, LIM);
    // R10: next start clears the flag and the run ends clean
    run_txn(8'h0C, 0, 32'h0, 2, 3, 40'h02_01_A0, 0, 1'b0, 0);
    // R2: stale byte in receive path is cleared before the opcode
    @(negedge clk);
    rx_mem.push_back(8'h77);
    repeat (2) @(negedge clk);
    run_txn(8'h11, 0, 32'h0, 2, 3, 40'h0F_F0_3E, 0, 1'b0, 0);
    chk("R2 stale byte dropped", rx_mem.size(), 0);
    // R11: start during a transaction is ignored
    run_txn(8'h2F, 1, 32'h0000_0019, 1, 2, 40'h55_E1, 0, 1'b0, 1);
    repeat (5) @(negedge clk);
    chk("R11 stays idle", busy, 0);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule